// File: doc/BRIEF.md
# SDRAM Command Decoder and Device State Tracker

This block watches the control pins of a single-data-rate synchronous DRAM from the device side. On every rising clock edge it samples chip select, the row strobe, the column strobe, the write enable, the data mask, the clock enable, the auto-precharge address bit and the bank address. It turns that sample into one command code. The decision uses the current and the previous clock-enable level and the tracked device state.

The tracker keeps one open/idle flag per bank and a device mode: normal, self refresh, power down or clock suspend. A power-down request made while the burst-activity input is high becomes clock suspend. A command that is not allowed in the present state raises an error flag for that cycle and leaves all tracked state as it was. The mask pin drives a registered data-enable output. An auto-precharge read or write closes its bank when the burst-done input pulses.

All outputs are registered. A sample taken at one rising edge appears on the outputs just after that edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted and after it is released, before any edge, cmd_o is 0, cmd_err_o is 0, dev_state_o is 0 (normal), bank_open_o is all zero and data_en_o is 0.
- R2: In normal mode, with clock enable high in both this and the previous sample, the pins decode as follows. With chip select high the code is 1 (deselect). With chip select low, {ras_n,cas_n,we_n} decodes as: 111 or 110 → 0 (no operation), 011 → 2 (activate), 101 → read, 100 → write, 010 → precharge, 000 → 9 (mode set), 001 → 10 (refresh).
- R3: a10_i picks the variant. Read is 3 when low and 4 (auto-precharge) when high. Write is 5 or 6 the same way. Precharge is 7 (one bank, chosen by ba_i) when low and 8 (all banks) when high.
- R4: Refresh pins with clock enable going from high to low give code 11 and enter self refresh (dev_state_o=1). Refresh and self-refresh entry are legal only when every bank is idle.
- R5: In self refresh or power down, a sample with the previous clock enable low, clock enable high and deselect or no-operation pins gives 12 (self refresh) or 14 (power down) exit and returns to normal. Every other sample gives code 17 (ignored) with no error and no state change.
- R6: In normal mode, clock enable going high to low with deselect or no-operation pins enters power down (code 13, dev_state_o=2). If burst_active_i is high it enters clock suspend instead (code 15, dev_state_o=3). Clock suspend ends with code 16 on the first sample with clock enable high, and code 17 applies until then.
- R7: Activate sets the addressed bank flag. Precharge clears the addressed bank and precharge-all clears every bank. After a legal auto-precharge read or write, a burst_done_i pulse clears that bank.
- R8: Activate and one-bank mode set checks: activate requires the addressed bank idle and mode set requires all banks idle. Read and write require the addressed bank open. A violation gives cmd_err_o=1 for that sample, with the command code still reported, and no change to banks or mode.
- R9: data_en_o equals the inverse of dqm_i from the previous edge. dqm_i has no effect on the command code.
- R10: In normal mode, clock enable falling with any pins other than deselect, no-operation or refresh gives code 18 and cmd_err_o=1. A normal-mode sample whose previous clock enable was low gives code 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm_i | input | 1 | Data mask, high disables data |
| cke_i | input | 1 | Clock enable |
| a10_i | input | 1 | Auto-precharge / all-banks select |
| ba_i | input | 2 | Bank address |
| burst_active_i | input | 1 | A burst is in progress |
| burst_done_i | input | 1 | Pending auto-precharge burst has finished |
| cmd_o | output | 5 | Decoded command code |
| cmd_err_o | output | 1 | Command illegal in current state |
| dev_state_o | output | 2 | 0 normal, 1 self refresh, 2 power down, 3 clock suspend |
| bank_open_o | output | 4 | One flag per bank, 1 = open |
| data_en_o | output | 1 | Data write/output enable |

## Verification
The assertions treat burst_active_i and burst_done_i as free inputs. They rely only on reset being released away from a clock edge, so the first checked sample follows a full cycle of defined pins. Because of this, the bench drives every input from $urandom with no ordering restriction between the burst inputs and the commands. It keeps clock enable high most of the time so that the normal-mode commands dominate. Low-power entries and exits are still reached repeatedly. Directed sequences fill in the corners: illegal commands against open and closed banks, the burst-time suspend and the falling clock enable with a non-idle command.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [4:0] {
    CMD_NOP    = 5'd0,
    CMD_DESEL  = 5'd1,
    CMD_ACT    = 5'd2,
    CMD_RD     = 5'd3,
    CMD_RDA    = 5'd4,
    CMD_WR     = 5'd5,
    CMD_WRA    = 5'd6,
    CMD_PRE    = 5'd7,
    CMD_PREA   = 5'd8,
    CMD_MRS    = 5'd9,
    CMD_REF    = 5'd10,
    CMD_SRE    = 5'd11,
    CMD_SRX    = 5'd12,
    CMD_PDE    = 5'd13,
    CMD_PDX    = 5'd14,
    CMD_CSE    = 5'd15,
    CMD_CSX    = 5'd16,
    CMD_IGN    = 5'd17,
    CMD_BADCKE = 5'd18
  } cmd_e;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_SREF = 2'd1,
    ST_PDN  = 2'd2,
    ST_SUSP = 2'd3
  } dev_st_e;

  typedef enum logic [2:0] {
    PIN_DESEL, PIN_NOP, PIN_ACT, PIN_RD, PIN_WR, PIN_PRE, PIN_REF, PIN_MRS
  } pin_e;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output pin_e pin_o
);

  always_comb begin
    if (cs_n) begin
      pin_o = PIN_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  pin_o = PIN_ACT;
        3'b101:  pin_o = PIN_RD;
        3'b100:  pin_o = PIN_WR;
        3'b010:  pin_o = PIN_PRE;
        3'b001:  pin_o = PIN_REF;
        3'b000:  pin_o = PIN_MRS;
        default: pin_o = PIN_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_en_i,
  input  logic                 pre_en_i,
  input  logic                 prea_en_i,
  input  logic                 ap_set_i,
  input  logic [BA_W-1:0]      bank_sel_i,
  input  logic                 burst_done_i,
  output logic [NUM_BANKS-1:0] open_o
);

  logic [NUM_BANKS-1:0] open_q, open_nx;
  logic                 apv_q, apv_nx;
  logic [BA_W-1:0]      apb_q, apb_nx;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      open_nx[b] = open_q[b];
      if (burst_done_i && apv_q && (apb_q == BA_W'(b))) open_nx[b] = 1'b0;
      if (prea_en_i) open_nx[b] = 1'b0;
      if (pre_en_i && (bank_sel_i == BA_W'(b))) open_nx[b] = 1'b0;
      if (act_en_i && (bank_sel_i == BA_W'(b))) open_nx[b] = 1'b1;
    end
  end

  always_comb begin
    apv_nx = apv_q;
    apb_nx = apb_q;
    if (ap_set_i) begin
      apv_nx = 1'b1;
      apb_nx = bank_sel_i;
    end else if (burst_done_i || prea_en_i || (pre_en_i && (bank_sel_i == apb_q))) begin
      apv_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      apv_q  <= 1'b0;
      apb_q  <= '0;
    end else begin
      open_q <= open_nx;
      apv_q  <= apv_nx;
      apb_q  <= apb_nx;
    end
  end

  assign open_o = open_q;

  // R7: a granted activate leaves its bank open
  assert_act_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_en_i |=> open_q[$past(bank_sel_i)]);

  // R7: precharge-all leaves no bank open unless an activate came with it
  assert_prea_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prea_en_i && !act_en_i) |=> (open_q == '0));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 dqm_i,
  input  logic                 cke_i,
  input  logic                 a10_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 burst_active_i,
  input  logic                 burst_done_i,
  output logic [4:0]           cmd_o,
  output logic                 cmd_err_o,
  output logic [1:0]           dev_state_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 data_en_o
);

  pin_e    pin;
  dev_st_e st_q, st_nx;
  cmd_e    cmd_q, cmd_nx;
  logic    err_q, err_nx;
  logic    ckep_q, den_q;
  logic    act_en, pre_en, prea_en, ap_set;
  logic    quiet, all_idle, sel_open;
  logic [NUM_BANKS-1:0] open_w;

  sdram_pin_decode u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .pin_o (pin)
  );

  sdram_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_en_i     (act_en),
    .pre_en_i     (pre_en),
    .prea_en_i    (prea_en),
    .ap_set_i     (ap_set),
    .bank_sel_i   (ba_i),
    .burst_done_i (burst_done_i),
    .open_o       (open_w)
  );

  assign quiet    = (pin == PIN_DESEL) || (pin == PIN_NOP);
  assign all_idle = ~|open_w;
  assign sel_open = open_w[ba_i];

  always_comb begin
    cmd_nx  = CMD_IGN;
    err_nx  = 1'b0;
    st_nx   = st_q;
    act_en  = 1'b0;
    pre_en  = 1'b0;
    prea_en = 1'b0;
    ap_set  = 1'b0;
    unique case (st_q)
      ST_SREF: begin
        if (!ckep_q && cke_i && quiet) begin
          cmd_nx = CMD_SRX;
          st_nx  = ST_NORM;
        end
      end
      ST_PDN: begin
        if (!ckep_q && cke_i && quiet) begin
          cmd_nx = CMD_PDX;
          st_nx  = ST_NORM;
        end
      end
      ST_SUSP: begin
        if (cke_i) begin
          cmd_nx = CMD_CSX;
          st_nx  = ST_NORM;
        end
      end
      default: begin
        if (!ckep_q) begin
          cmd_nx = CMD_IGN;
        end else if (!cke_i) begin
          if (quiet) begin
            cmd_nx = burst_active_i ? CMD_CSE : CMD_PDE;
            st_nx  = burst_active_i ? ST_SUSP : ST_PDN;
          end else if (pin == PIN_REF) begin
            cmd_nx = CMD_SRE;
            if (all_idle) st_nx = ST_SREF;
            else          err_nx = 1'b1;
          end else begin
            cmd_nx = CMD_BADCKE;
            err_nx = 1'b1;
          end
        end else begin
          unique case (pin)
            PIN_DESEL: cmd_nx = CMD_DESEL;
            PIN_NOP:   cmd_nx = CMD_NOP;
            PIN_ACT: begin
              cmd_nx = CMD_ACT;
              err_nx = sel_open;
              act_en = !sel_open;
            end
            PIN_RD, PIN_WR: begin
              if (pin == PIN_RD) cmd_nx = a10_i ? CMD_RDA : CMD_RD;
              else               cmd_nx = a10_i ? CMD_WRA : CMD_WR;
              err_nx = !sel_open;
              ap_set = sel_open && a10_i;
            end
            PIN_PRE: begin
              cmd_nx  = a10_i ? CMD_PREA : CMD_PRE;
              prea_en = a10_i;
              pre_en  = !a10_i;
            end
            PIN_MRS: begin
              cmd_nx = CMD_MRS;
              err_nx = !all_idle;
            end
            default: begin
              cmd_nx = CMD_REF;
              err_nx = !all_idle;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_NORM;
      cmd_q  <= CMD_NOP;
      err_q  <= 1'b0;
      ckep_q <= 1'b1;
      den_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      cmd_q  <= cmd_nx;
      err_q  <= err_nx;
      ckep_q <= cke_i;
      den_q  <= !dqm_i;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_err_o   = err_q;
  assign dev_state_o = st_q;
  assign bank_open_o = open_w;
  assign data_en_o   = den_q;

  // R8: a flagged command leaves the device mode where it was
  assert_err_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == $past(st_q)));

  // R5: self refresh can only be left towards normal mode
  assert_sref_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SREF) |=> ((st_q == ST_SREF) || (st_q == ST_NORM)));

  // R6: clock suspend is entered only during a burst
  assert_susp_needs_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_NORM) && (st_nx == ST_SUSP)) |-> burst_active_i);

  // R9: the data enable follows the mask one edge later
  assert_data_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_en_o == !$past(dqm_i)));

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic dqm = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic bact = 1'b0, bdone = 1'b0;
  logic [4:0] cmd;
  logic err, den;
  logic [1:0] st;
  logic [3:0] bopen;

  int checks = 0, failures = 0, cycles = 0;

  // model state
  int m_cmd = 0, m_st = 0;
  bit m_err = 0, m_den = 0, m_ckep = 1, m_apv = 0;
  bit [3:0] m_open = 0;
  bit [1:0] m_apb = 0;

  always #10 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dqm_i(dqm), .cke_i(cke), .a10_i(a10), .ba_i(ba),
    .burst_active_i(bact), .burst_done_i(bdone), .cmd_o(cmd),
    .cmd_err_o(err), .dev_state_o(st), .bank_open_o(bopen), .data_en_o(den)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin class: 0 desel 1 nop 2 act 3 rd 4 wr 5 pre 6 ref 7 mrs
  function automatic int pin_class(bit c, bit r, bit s, bit w);
    if (c) return 0;
    case ({r, s, w})
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return 4;
      3'b010: return 5;
      3'b001: return 6;
      3'b000: return 7;
      default: return 1;
    endcase
  endfunction

  task automatic model_step();
    int pc, ncmd, nst;
    bit nerr, quiet, idle, selo, act, pre, prea, aps;
    bit [3:0] o;
    pc = pin_class(cs_n, ras_n, cas_n, we_n);
    quiet = (pc <= 1);
    idle = (m_open == 0);
    selo = m_open[ba];
    ncmd = 17; nerr = 0; nst = m_st;
    act = 0; pre = 0; prea = 0; aps = 0;
    if (m_st == 1 || m_st == 2) begin
      if (!m_ckep && cke && quiet) begin ncmd = (m_st == 1) ? 12 : 14; nst = 0; end
    end else if (m_st == 3) begin
      if (cke) begin ncmd = 16; nst = 0; end
    end else if (!m_ckep) begin
      ncmd = 17;
    end else if (!cke) begin
      if (quiet) begin ncmd = bact ? 15 : 13; nst = bact ? 3 : 2; end
      else if (pc == 6) begin ncmd = 11; if (idle) nst = 1; else nerr = 1; end
      else begin ncmd = 18; nerr = 1; end
    end else begin
      case (pc)
        0: ncmd = 1;
        1: ncmd = 0;
        2: begin ncmd = 2; nerr = selo; act = !selo; end
        3: begin ncmd = a10 ? 4 : 3; nerr = !selo; aps = selo && a10; end
        4: begin ncmd = a10 ? 6 : 5; nerr = !selo; aps = selo && a10; end
        5: begin ncmd = a10 ? 8 : 7; prea = a10; pre = !a10; end
        7: begin ncmd = 9; nerr = !idle; end
        default: begin ncmd = 10; nerr = !idle; end
      endcase
    end
    o = m_open;
    if (bdone && m_apv) o[m_apb] = 0;
    if (prea) o = 0;
    if (pre) o[ba] = 0;
    if (act) o[ba] = 1;
    if (aps) begin m_apv = 1; m_apb = ba; end
    else if (bdone || prea || (pre && ba == m_apb)) m_apv = 0;
    m_open = o; m_cmd = ncmd; m_err = nerr; m_st = nst;
    m_ckep = cke; m_den = !dqm;
  endtask

  task automatic compare_all();
    chk(cmd, m_cmd, "R2 command code");
    chk(err, m_err, "R8 error flag");
    chk(st, m_st, "R6 device mode");
    chk(bopen, m_open, "R7 bank flags");
    chk(den, m_den, "R9 data enable");
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    compare_all();
    @(negedge clk);
  endtask

  // set pins: pc class as in pin_class
  task automatic pins(int pc, bit a, bit [1:0] b, bit k);
    cs_n = (pc == 0);
    case (pc)
      2: {ras_n, cas_n, we_n} = 3'b011;
      3: {ras_n, cas_n, we_n} = 3'b101;
      4: {ras_n, cas_n, we_n} = 3'b100;
      5: {ras_n, cas_n, we_n} = 3'b010;
      6: {ras_n, cas_n, we_n} = 3'b001;
      7: {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    a10 = a; ba = b; cke = k;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd, 0, "R1 reset cmd"); chk(err, 0, "R1 reset err");
    chk(st, 0, "R1 reset mode"); chk(bopen, 0, "R1 reset banks");
    chk(den, 0, "R1 reset data enable");
    #3 rst_n = 1'b1;
    @(negedge clk);

    pins(1, 0, 0, 1); dqm = 0; tick(); chk(cmd, 0, "R2 nop");
    chk(den, 1, "R9 dqm low enables");
    pins(2, 0, 1, 1); tick(); chk(cmd, 2, "R2 activate"); chk(bopen, 4'b0010, "R7 activate bank1");
    pins(3, 0, 1, 1); dqm = 1; tick(); chk(cmd, 3, "R2 read"); chk(den, 0, "R9 dqm high disables");
    pins(3, 1, 1, 1); dqm = 0; tick(); chk(cmd, 4, "R3 read auto-precharge");
    pins(5, 0, 1, 1); tick(); chk(cmd, 7, "R3 precharge one bank"); chk(bopen, 0, "R7 precharge closes");
    pins(2, 0, 1, 1); tick();
    pins(4, 1, 1, 1); tick(); chk(cmd, 6, "R3 write auto-precharge");
    pins(3, 0, 2, 1); tick(); chk(err, 1, "R8 read closed bank"); chk(cmd, 3, "R8 code kept");
    pins(2, 0, 1, 1); tick(); chk(err, 1, "R8 activate open bank");
    pins(7, 0, 0, 1); tick(); chk(err, 1, "R8 mode set with open bank");
    pins(6, 0, 0, 1); tick(); chk(err, 1, "R4 refresh with open bank");
    pins(1, 0, 0, 1); bdone = 1; tick(); bdone = 0; chk(bopen, 0, "R7 burst done closes");
    pins(2, 0, 0, 1); tick(); pins(2, 0, 3, 1); tick();
    pins(5, 1, 0, 1); tick(); chk(cmd, 8, "R3 precharge all"); chk(bopen, 0, "R7 all closed");
    pins(6, 0, 0, 1); tick(); chk(cmd, 10, "R4 refresh"); chk(err, 0, "R4 refresh legal");
    pins(6, 0, 0, 0); tick(); chk(cmd, 11, "R4 self refresh entry"); chk(st, 1, "R4 in self refresh");
    pins(2, 0, 0, 0); tick(); chk(cmd, 17, "R5 ignored in self refresh"); chk(bopen, 0, "R5 no activate");
    pins(2, 0, 0, 1); tick(); chk(cmd, 17, "R5 busy pins no exit"); chk(st, 1, "R5 still self refresh");
    pins(1, 0, 0, 0); tick();
    pins(0, 0, 0, 1); tick(); chk(cmd, 12, "R5 self refresh exit"); chk(st, 0, "R5 back to normal");
    pins(2, 0, 2, 1); tick();
    pins(1, 0, 0, 0); bact = 0; tick(); chk(cmd, 13, "R6 power down entry"); chk(st, 2, "R6 power down");
    pins(0, 0, 0, 1); tick(); chk(cmd, 14, "R5 power down exit");
    pins(0, 0, 0, 0); bact = 1; tick(); chk(cmd, 15, "R6 suspend entry"); chk(st, 3, "R6 suspend");
    pins(3, 0, 2, 0); tick(); chk(cmd, 17, "R6 suspended ignore");
    pins(1, 0, 0, 1); bact = 0; tick(); chk(cmd, 16, "R6 suspend exit"); chk(st, 0, "R6 normal again");
    pins(3, 0, 2, 0); tick(); chk(cmd, 18, "R10 cke fall busy"); chk(err, 1, "R10 error");
    pins(1, 0, 0, 0); tick(); chk(cmd, 17, "R10 previous cke low");
    pins(1, 0, 0, 1); tick(); chk(cmd, 17, "R10 rising cke in normal");
    pins(1, 0, 0, 1); tick(); chk(cmd, 0, "R2 nop after recovery");

    for (int i = 0; i < 4000; i++) begin
      int pc;
      pc = ($urandom % 5 == 0) ? 0 : 1 + ($urandom % 7);
      pins(pc, $urandom % 2, $urandom % 4, ($urandom % 8) != 0);
      dqm = $urandom % 2;
      bact = ($urandom % 4) == 0;
      bdone = ($urandom % 10) == 0;
      tick();
    end

    summary();
    $finish;
  end

endmodule